// File: doc/BRIEF.md
# Pulsed-Laser Round-Trip Distance Timer

This block measures the distance to a reflecting object by timing how long a light pulse takes to come back. While idle it watches a push button. A press makes it drive the laser enable high for one clock cycle. It then counts clock cycles until the reflection sensor reports an echo. Half of that count is kept in a distance register, which holds its value until the next measurement finishes.

With a 300 MHz clock and light at 3×10^8 m/s, one cycle of round-trip time is 1 m of path. Halving the count therefore gives the one-way distance in metres. If no reflection arrives, the cycle counter stops at its all-ones value and does not wrap, so a missing echo reads as the largest distance the register can show.

The block has three parts. A five-state controller drives four datapath strobes and the laser enable. A saturating cycle counter does the timing. A result register stores the halved count. Reset is synchronous and active high.

Top module: `range_timer`

## Requirements
- R1: While reset is high and on the first cycle after it, `laser_on` is 0 and `dist_out` is 0.
- R2: In the idle state, `fire_btn` sampled high at a clock edge sets `laser_on` to 1 for exactly the next cycle. `laser_on` is 0 again after the following edge.
- R3: N is the number of clock edges after the laser cycle at which `echo_in` is sampled low, before the first edge at which it is sampled high. The stored result is floor(N/2) whenever N is below 2^CNT_W − 1.
- R4: When N is 2^CNT_W − 1 or larger, the counter saturates. The stored result is (2^CNT_W − 1) >> 1.
- R5: `dist_out` keeps its old value at the edge that samples `echo_in` high. It takes the new result at the edge after that.
- R6: `fire_btn` has no effect while a measurement is running, from the laser cycle up to the result load. No second laser cycle occurs.
- R7: `echo_in` has no effect while the block is idle. `laser_on` stays 0 and `dist_out` is unchanged.
- R8: `dist_out` holds its value while idle. A new press is accepted in the cycle right after the result load, so measurements can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fire_btn | input | 1 | Start request (button), sampled while idle |
| echo_in | input | 1 | Reflection sensor, high when the echo is seen |
| laser_on | output | 1 | Laser enable, one-cycle pulse per measurement |
| dist_out | output | CNT_W | Halved round-trip count (distance) |

## Verification
The bench builds the block with CNT_W = 8. This puts the saturation point at 255 cycles, so it can be reached in a short run. A sweep of the echo delay from 0 to 300 cycles covers every counter value of both parities, the exact saturation boundary, and delays well past it. Each measurement also checks the width of the laser pulse and the load latency of the result. Separate phases press the button during timing, raise the echo while idle, and start a new measurement in the cycle right after a load.

// File: rtl/range_timer_pkg.sv
package range_timer_pkg;

    // Controller states; the order is the measurement sequence.
    typedef enum logic [2:0] {
        ST_BOOT  = 3'd0,  // clear result register
        ST_ARM   = 3'd1,  // clear counter, wait for button
        ST_PULSE = 3'd2,  // laser on for one cycle
        ST_TIME  = 3'd3,  // count until echo
        ST_LATCH = 3'd4   // load halved count
    } rt_state_e;

    // Strobes from controller to datapath.
    typedef struct packed {
        logic dist_clr;
        logic dist_ld;
        logic cnt_clr;
        logic cnt_en;
        logic laser;
    } rt_cmd_t;

    typedef struct packed {
        rt_state_e state;
    } rt_ctrl_regs_t;

endpackage

// File: rtl/range_ctrl.sv
module range_ctrl
    import range_timer_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fire_btn,
    input  logic    echo_in,
    output rt_cmd_t cmd
);

    rt_ctrl_regs_t regs_d;
    rt_ctrl_regs_t regs_q;

    always_comb begin
        regs_d = regs_q;
        cmd    = '0;
        case (regs_q.state)
            ST_BOOT: begin
                cmd.dist_clr = 1'b1;
                regs_d.state = ST_ARM;
            end
            ST_ARM: begin
                cmd.cnt_clr = 1'b1;
                if (fire_btn) begin
                    regs_d.state = ST_PULSE;
                end
            end
            ST_PULSE: begin
                cmd.laser    = 1'b1;
                regs_d.state = ST_TIME;
            end
            ST_TIME: begin
                if (echo_in) begin
                    regs_d.state = ST_LATCH;
                end else begin
                    cmd.cnt_en = 1'b1;
                end
            end
            ST_LATCH: begin
                cmd.dist_ld  = 1'b1;
                regs_d.state = ST_ARM;
            end
            default: begin
                regs_d.state = ST_BOOT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.state <= ST_BOOT;
        end else begin
            regs_q <= regs_d;
        end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.dist_clr, cmd.dist_ld, cmd.cnt_clr, cmd.cnt_en, cmd.laser})); // R3

    AST_LASER_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd.laser |=> !cmd.laser); // R2

    AST_TIMING_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
        (regs_q.state == ST_TIME) |=> !cmd.laser); // R6

endmodule

// File: rtl/range_counter.sv
module range_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R3

endmodule

// File: rtl/range_result.sv
module range_result #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] dist_q
);

    logic [CNT_W-1:0] dist_d;

    always_comb begin
        dist_d = dist_q;
        if (clr) begin
            dist_d = '0;
        end else if (ld) begin
            dist_d = cnt >> 1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dist_q <= '0;
        end else begin
            dist_q <= dist_d;
        end
    end

    AST_DIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ld && !clr) |=> $stable(dist_q)); // R8

endmodule

// File: rtl/range_timer.sv
module range_timer
    import range_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_btn,
    input  logic             echo_in,
    output logic             laser_on,
    output logic [CNT_W-1:0] dist_out
);

    rt_cmd_t          cmd;
    logic [CNT_W-1:0] cnt;

    range_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .fire_btn (fire_btn),
        .echo_in  (echo_in),
        .cmd      (cmd)
    );

    range_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cmd.cnt_clr),
        .en    (cmd.cnt_en),
        .cnt_q (cnt)
    );

    range_result #(.CNT_W(CNT_W)) u_res (
        .clk    (clk),
        .rst    (rst),
        .clr    (cmd.dist_clr),
        .ld     (cmd.dist_ld),
        .cnt    (cnt),
        .dist_q (dist_out)
    );

    assign laser_on = cmd.laser;

    AST_FIRE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(laser_on) |-> $past(fire_btn)); // R2

    AST_RESULT_BOUND: assert property (@(posedge clk) disable iff (rst)
        dist_out[CNT_W-1] == 1'b0); // R4

endmodule

// File: tb/range_timer_test.sv
module range_timer_test;

    localparam int W    = 8;
    localparam int MAXC = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fire_btn = 1'b0;
    logic         echo_in = 1'b0;
    logic         laser_on;
    logic [W-1:0] dist_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    range_timer #(.CNT_W(W)) uut (
        .clk      (clk),
        .rst      (rst),
        .fire_btn (fire_btn),
        .echo_in  (echo_in),
        .laser_on (laser_on),
        .dist_out (dist_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // advance one edge, then settle away from it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // one full measurement with N low-echo cycles; busy_press holds the button during timing
    task automatic measure(input int n, input bit busy_press);
        int prev;
        int expd;
        prev = int'(dist_out);
        expd = ((n > MAXC) ? MAXC : n) / 2;
        fire_btn = 1'b1;
        tick();
        chk("R2 laser high", int'(laser_on), 1);
        fire_btn = busy_press;
        tick();
        chk("R2 laser low", int'(laser_on), 0);
        for (int i = 0; i < n; i++) begin
            tick();
            if (busy_press) chk("R6 laser during timing", int'(laser_on), 0);
        end
        echo_in  = 1'b1;
        fire_btn = 1'b0;
        tick();
        chk("R5 old result kept", int'(dist_out), prev);
        echo_in = 1'b0;
        tick();
        if (n >= MAXC) chk("R4 saturated result", int'(dist_out), expd);
        else           chk("R3 halved count", int'(dist_out), expd);
    endtask

    initial begin
        #1;
        repeat (3) tick();
        chk("R1 laser in reset", int'(laser_on), 0);
        chk("R1 dist in reset", int'(dist_out), 0);
        rst = 1'b0;
        tick();
        chk("R1 laser after reset", int'(laser_on), 0);
        chk("R1 dist after reset", int'(dist_out), 0);
        tick();

        // R3 / R4 sweep over echo delays, back to back (R8)
        for (int n = 0; n <= 300; n++) begin
            measure(n, 1'b0);
        end

        // R7: echo while idle
        begin
            int held;
            measure(37, 1'b0);
            held = int'(dist_out);
            echo_in = 1'b1;
            for (int i = 0; i < 6; i++) begin
                tick();
                chk("R7 laser idle echo", int'(laser_on), 0);
                chk("R7 dist idle echo", int'(dist_out), held);
            end
            echo_in = 1'b0;
            for (int i = 0; i < 10; i++) begin
                tick();
                chk("R8 dist held idle", int'(dist_out), held);
            end
        end

        // R6: button held through timing
        measure(20, 1'b1);
        measure(5, 1'b1);
        measure(260, 1'b1);
        measure(2, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule